// File: doc/BRIEF.md
# Two-Wire Bus Activity Monitor with Arbitration Check

This block sits beside a local master on a shared two-wire serial bus (clock line SCL, data line SDA). Both lines pass through a synchronizer. The block then finds START, repeated START and STOP conditions on the bus. It keeps two sticky status bits that record whether the last condition seen was a START or a STOP, and derives from them whether this master may try to claim the bus.

The local master's byte shifter and acknowledge sequencer stay outside this block. They report their current phase as a one-hot-ish vector and pulse when a byte or an acknowledge has finished. The block compares the SDA level the master intends, using a release flag, against the sampled line during every phase where arbitration can be lost. A loss sets a sticky collision flag. A second sticky flag gathers the interrupt events. Software clears each flag with a one-cycle pulse.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, and on any cycle in which `enable` is low, `start_seen`, `stop_seen`, `irq_flag`, `bcl_flag` and `rstart_pulse` are 0 and `bus_free` is 1.
- R2: A START (synchronized SDA falls while synchronized SCL is high) sets `start_seen` and clears `stop_seen`; the status shows it at most 3 clock cycles after the line change reaches the pins.
- R3: A STOP (synchronized SDA rises while synchronized SCL is high) sets `stop_seen` and clears `start_seen`.
- R4: `bus_free` is 1 exactly when `stop_seen` is 1 or both status bits are 0.
- R5: A START detected while `start_seen` is already 1 gives a one-cycle `rstart_pulse`. A first START gives none.
- R6: `irq_flag` is set by a START, a repeated START, a STOP, a `byte_done` pulse or an `ack_done` pulse. `irq` is the registered AND of `irq_flag` and `irq_en`.
- R7: `irq_flag` and `bcl_flag` stay set until their clear pulse (`irq_clr`, `bcl_clr`). A clear and a new setting event in the same cycle leave the flag set.
- R8: `bcl_flag` is set when any bit of `phase_vec` is 1, SCL is high, `sda_release` is 1 and SDA is sampled low. The bits of `phase_vec` are: bit 0 address, bit 1 data, bit 2 START, bit 3 repeated START, bit 4 acknowledge.
- R9: No collision is flagged while `phase_vec` is zero, SCL is low, `sda_release` is 0 or SDA is high.
- R10: SDA edges while SCL is low are not conditions: the status bits and `irq_flag` stay unchanged.
- R11: While `enable` is low, bus conditions and `byte_done`/`ack_done` pulses have no effect, and re-enabling with steady lines creates no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Monitor enable; low clears all status |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| sda_release | input | 1 | 1 when the local master leaves SDA high |
| phase_vec | input | 5 | Arbitration phases active: address, data, START, repeated START, acknowledge |
| byte_done | input | 1 | Pulse: byte sent or received |
| ack_done | input | 1 | Pulse: acknowledge sent |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Pulse clearing `irq_flag` |
| bcl_clr | input | 1 | Pulse clearing `bcl_flag` |
| start_seen | output | 1 | Last condition was a START |
| stop_seen | output | 1 | Last condition was a STOP |
| bus_free | output | 1 | Bus may be claimed |
| rstart_pulse | output | 1 | One-cycle repeated START indication |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Gated interrupt request |
| bcl_flag | output | 1 | Sticky bus collision flag |

## Verification
The condition detector is driven through an ordered line sequence: a first START, SDA toggling with SCL low, a START while already busy, and a STOP. This separates a plain START from a repeated one, and a true condition from a data edge. The collision check is swept over all 256 combinations of the five phase bits, SCL, SDA and the release flag. This sweep separates the one mismatch that counts from a drive-low, a clock-low and an idle phase. The flag tests pair a clear with a coincident event, so that event priority is told apart from a plain clear. A disabled period that contains both a START and a byte pulse shows that the enable gates every source.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int unsigned PH_W = 5;
  // bit positions inside the phase vector
  typedef enum logic [2:0] {
    PH_ADDR   = 3'd0,
    PH_DATA   = 3'd1,
    PH_START  = 3'd2,
    PH_RSTART = 3'd3,
    PH_ACK    = 3'd4
  } phase_bit_e;
endpackage

// File: rtl/bw_sync.sv
module bw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/bw_cond.sv
module bw_cond (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic start_p,
  output logic stop_p,
  output logic rstart_p
);
  logic sda_d;
  logic start_det, stop_det;
  logic nxt_start, nxt_stop;

  assign start_det = scl_s &  sda_d & ~sda_s;
  assign stop_det  = scl_s & ~sda_d &  sda_s;

  always_comb begin
    nxt_start = start_seen;
    nxt_stop  = stop_seen;
    if (start_det) begin
      nxt_start = 1'b1;
      nxt_stop  = 1'b0;
    end else if (stop_det) begin
      nxt_start = 1'b0;
      nxt_stop  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sda_d <= 1'b1;
    else     sda_d <= sda_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      bus_free   <= 1'b1;
      start_p    <= 1'b0;
      stop_p     <= 1'b0;
      rstart_p   <= 1'b0;
    end else begin
      start_seen <= nxt_start;
      stop_seen  <= nxt_stop;
      bus_free   <= nxt_stop | ~nxt_start;
      start_p    <= start_det;
      stop_p     <= stop_det;
      rstart_p   <= start_det & start_seen;
    end
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(start_seen && stop_seen));
  p_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (start_seen && !stop_seen) |-> !bus_free);
  p_rstart_r5: assert property (@(posedge clk) disable iff (rst)
    rstart_p |-> $past(start_seen));
  p_off_r11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!start_seen && !stop_seen && !rstart_p));
endmodule

// File: rtl/bw_arb.sv
module bw_arb #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [PW-1:0] phase,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          sda_rel,
  input  logic          bcl_clr,
  output logic          bcl_flag
);
  logic lost;
  assign lost = (|phase) & scl_s & sda_rel & ~sda_s;

  always_ff @(posedge clk) begin
    if (rst || !enable) bcl_flag <= 1'b0;
    else if (lost)      bcl_flag <= 1'b1;
    else if (bcl_clr)   bcl_flag <= 1'b0;
  end

  p_bcl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (bcl_flag && enable && !bcl_clr) |=> bcl_flag);
  p_bcl_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bcl_flag) |-> $past((|phase) && sda_rel && !sda_s));
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import bw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic            sda_release,
  input  logic [PH_W-1:0] phase_vec,
  input  logic            byte_done,
  input  logic            ack_done,
  input  logic            irq_en,
  input  logic            irq_clr,
  input  logic            bcl_clr,
  output logic            start_seen,
  output logic            stop_seen,
  output logic            bus_free,
  output logic            rstart_pulse,
  output logic            irq_flag,
  output logic            irq,
  output logic            bcl_flag
);
  logic [1:0] lines_s;
  logic       start_p, stop_p;
  logic       ev;

  bw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );

  bw_cond u_cond (
    .clk(clk), .rst(rst), .enable(enable),
    .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .start_p(start_p), .stop_p(stop_p), .rstart_p(rstart_pulse)
  );

  bw_arb #(.PW(PH_W)) u_arb (
    .clk(clk), .rst(rst), .enable(enable), .phase(phase_vec),
    .scl_s(lines_s[1]), .sda_s(lines_s[0]), .sda_rel(sda_release),
    .bcl_clr(bcl_clr), .bcl_flag(bcl_flag)
  );

  assign ev = start_p | stop_p | byte_done | ack_done;

  always_ff @(posedge clk) begin
    if (rst || !enable) irq_flag <= 1'b0;
    else if (ev)        irq_flag <= 1'b1;
    else if (irq_clr)   irq_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_flag & irq_en;
  end

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && enable && !irq_clr) |=> irq_flag);
endmodule

// File: tb/sim_i2c_bus_watch.sv
module sim_i2c_bus_watch;
  import bw_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, enable, scl_in, sda_in, sda_release;
  logic [PH_W-1:0] phase_vec;
  logic byte_done, ack_done, irq_en, irq_clr, bcl_clr;
  logic start_seen, stop_seen, bus_free, rstart_pulse, irq_flag, irq, bcl_flag;

  int n_chk = 0, n_fail = 0, rs_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_bus_watch u0 (
    .clk(clk), .rst(rst), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
    .sda_release(sda_release), .phase_vec(phase_vec), .byte_done(byte_done),
    .ack_done(ack_done), .irq_en(irq_en), .irq_clr(irq_clr), .bcl_clr(bcl_clr),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .rstart_pulse(rstart_pulse), .irq_flag(irq_flag), .irq(irq), .bcl_flag(bcl_flag)
  );

  always @(negedge clk) if (rstart_pulse) rs_cnt++;

  task automatic chk(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  task automatic chk_idle(string req);
    chk({req, " start_seen"}, start_seen, 1'b0);
    chk({req, " stop_seen"},  stop_seen,  1'b0);
    chk({req, " bus_free"},   bus_free,   1'b1);
    chk({req, " irq_flag"},   irq_flag,   1'b0);
    chk({req, " bcl_flag"},   bcl_flag,   1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; scl_in = 1'b1; sda_in = 1'b1; sda_release = 1'b1;
    phase_vec = '0; byte_done = 1'b0; ack_done = 1'b0; irq_en = 1'b0;
    irq_clr = 1'b0; bcl_clr = 1'b0;
    wt(4);
    rst = 1'b0; enable = 1'b1;
    wt(4);
    chk_idle("R1 reset");

    // first START: sampled within 3 cycles
    sda_in = 1'b0;
    wt(3);
    chk("R2 start_seen", start_seen, 1'b1);
    chk("R2 stop_seen", stop_seen, 1'b0);
    chk("R4 bus_free busy", bus_free, 1'b0);
    wt(3);
    chk("R5 no rstart on first START", rs_cnt == 0, 1'b1);
    chk("R6 irq_flag on START", irq_flag, 1'b1);
    chk("R6 irq gated off", irq, 1'b0);
    pulse_irq_clr();
    wt(2);
    chk("R7 irq_flag cleared", irq_flag, 1'b0);

    // data edges with SCL low
    scl_in = 1'b0; wt(6);
    sda_in = 1'b1; wt(6);
    sda_in = 1'b0; wt(6);
    sda_in = 1'b1; wt(6);
    chk("R10 start_seen kept", start_seen, 1'b1);
    chk("R10 stop_seen kept", stop_seen, 1'b0);
    chk("R10 no irq", irq_flag, 1'b0);
    scl_in = 1'b1; wt(6);
    chk("R10 SCL rise no event", irq_flag, 1'b0);

    // repeated START
    sda_in = 1'b0; wt(6);
    chk("R5 rstart pulse count", rs_cnt == 1, 1'b1);
    chk("R6 irq_flag on rSTART", irq_flag, 1'b1);
    chk("R5 start_seen", start_seen, 1'b1);
    pulse_irq_clr();
    irq_en = 1'b1;
    wt(2);

    // STOP
    sda_in = 1'b1; wt(6);
    chk("R3 stop_seen", stop_seen, 1'b1);
    chk("R3 start_seen", start_seen, 1'b0);
    chk("R4 bus_free after STOP", bus_free, 1'b1);
    chk("R6 irq_flag on STOP", irq_flag, 1'b1);
    chk("R6 irq enabled", irq, 1'b1);
    chk("R5 STOP no rstart", rs_cnt == 1, 1'b1);

    // clear vs event in the same cycle
    pulse_irq_clr(); wt(2);
    chk("R7 cleared", irq_flag, 1'b0);
    chk("R6 irq follows", irq, 1'b0);
    @(negedge clk) begin irq_clr = 1'b1; byte_done = 1'b1; end
    @(negedge clk) begin irq_clr = 1'b0; byte_done = 1'b0; end
    wt(1);
    chk("R7 event beats clear", irq_flag, 1'b1);
    pulse_irq_clr(); wt(1);
    @(negedge clk) ack_done = 1'b1;
    @(negedge clk) ack_done = 1'b0;
    chk("R6 irq_flag on ack_done", irq_flag, 1'b1);

    // collision sweep
    for (int v = 0; v < 256; v++) begin
      logic exp_b;
      @(negedge clk) begin phase_vec = '0; bcl_clr = 1'b1; end
      @(negedge clk) bcl_clr = 1'b0;
      phase_vec   = v[4:0];
      scl_in      = v[5];
      sda_in      = v[6];
      sda_release = v[7];
      wt(4);
      exp_b = (v[4:0] != 0) && v[5] && v[7] && !v[6];
      if (exp_b) chk($sformatf("R8 collision v=%0d", v), bcl_flag, 1'b1);
      else       chk($sformatf("R9 no collision v=%0d", v), bcl_flag, 1'b0);
    end
    // last combo (v=255) has SDA high: force a hit then remove it
    phase_vec = 5'b10000; scl_in = 1'b1; sda_release = 1'b1; sda_in = 1'b0; wt(4);
    phase_vec = '0; sda_in = 1'b1; wt(4);
    chk("R7 bcl_flag sticky", bcl_flag, 1'b1);
    @(negedge clk) bcl_clr = 1'b1;
    @(negedge clk) bcl_clr = 1'b0;
    chk("R7 bcl_flag cleared", bcl_flag, 1'b0);

    // disable
    sda_in = 1'b0; wt(6);
    chk("R2 start before disable", start_seen, 1'b1);
    enable = 1'b0; wt(2);
    chk_idle("R1 disabled");
    sda_in = 1'b1; wt(6);
    sda_in = 1'b0; wt(2);
    @(negedge clk) byte_done = 1'b1;
    @(negedge clk) byte_done = 1'b0;
    wt(4);
    chk("R11 START ignored", start_seen, 1'b0);
    chk("R11 byte_done ignored", irq_flag, 1'b0);
    enable = 1'b1; wt(6);
    chk_idle("R11 re-enable");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule